// File: doc/BRIEF.md
# Register-Programmed Sine Oscillator with Gain and Offset

This block generates a digital sine wave for a 14-bit signed DAC and is configured over a simple memory-mapped register port. A 24-bit phase accumulator grows by a programmable step on every clock. Its top eight bits select one of 256 entries in a 10-bit sine table. The selected sample is scaled by a programmable gain, shifted by a programmable signed offset, and clipped to the 14-bit range. At a 125 MHz clock the tone frequency is step × 125e6 / 2^24.

Software programs the step, gain and offset through the register port. Each access is acknowledged one cycle after its enable. Only the low 20 address bits are decoded. The three control registers read back their contents. Every other address returns a fixed identification word, so a driver can detect the block. The current table index is also brought out so that the phase rate can be observed.

Top module: `nco_bus_sine`

## Requirements
- R1: The 24-bit accumulator adds bits [23:0] of the step register on every clock and wraps modulo 2^24. `lut_index` always equals accumulator bits [23:16].
- R2: Table entry i (0..255) holds round(511 × sin(2πi/256)) as a 10-bit two's-complement value, with halves rounded away from zero.
- R3: The output is the table sample times 16, times the gain, arithmetically shifted right by 12 (floor), plus the offset. The result is clipped to −8192..8191.
- R4: `dac_out` reflects the table entry that `lut_index` selected two clocks earlier.
- R5: Only address bits [19:0] are decoded. The step register is at 0x10004. It stores all 32 written bits and reads them back unchanged.
- R6: The gain register is at 0x10008. It keeps wdata[12:0] and reads back zero-extended; 0x1000 means a gain of one. The offset register is at 0x1000C. It keeps wdata[13:0] as a signed value and reads back sign-extended to 32 bits.
- R7: A read from any decoded address other than the three registers returns 0xFE002020.
- R8: `bus_ack` is high in the cycle after each cycle in which `bus_wen` or `bus_ren` is high, and low otherwise. Read data is valid together with `bus_ack`. `bus_err` is always 0.
- R9: Reset is synchronous and active low. It sets the step register and the accumulator to 0, the gain to 0x1000 and the offset to 0. It also clears the output and acknowledge registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Register address; bits [19:0] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_wen | input | 1 | Write enable, one cycle per access |
| bus_ren | input | 1 | Read enable, one cycle per access |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after the enable |
| bus_err | output | 1 | Bus error, always 0 |
| dac_out | output | 14 | Signed DAC sample |
| lut_index | output | 8 | Current sine table index |

## Verification
The oscillator is run with four combinations of step, gain and offset. A step of 10000 at unity gain covers one whole period, so every output sample exposes the raw table value and the exact index progression exposes the step rate. A full-scale gain with a large positive offset drives both clip limits. A half gain with a negative offset separates floor rounding from truncation, clips only the low side and checks the two-cycle pipeline. A step of 0xABFFFFFF with zero gain shows that the upper step bits are ignored, that the index wraps backwards, and that the output reduces to the offset. Register reads at mapped, unmapped and high-bit-aliased addresses cover decoding, field widths and sign extension.

// File: rtl/nco_pkg.sv
// nco_pkg: shared constants, register select type and the constant
// functions that build the sine table at elaboration time.
// Assumes: table depth is a multiple of four (quarter-wave symmetry).
package nco_pkg;

    localparam int DEC_W = 20;

    localparam logic [DEC_W-1:0] OFS_STEP = 20'h10004;
    localparam logic [DEC_W-1:0] OFS_GAIN = 20'h10008;
    localparam logic [DEC_W-1:0] OFS_BIAS = 20'h1000C;

    localparam logic [31:0] ID_WORD = 32'hFE002020;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STEP,
        SEL_GAIN,
        SEL_BIAS
    } reg_sel_e;

    // pi scaled by 2^30
    localparam longint PI_Q30 = 64'sd3373259426;

    // Rounded peak*sin(pi/2 * k/qn) for 0 <= k <= qn, using a Q30 Taylor series
    function automatic longint quarter_sine(int k, int qn, longint peak);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (PI_Q30 * longint'(k)) / longint'(2 * qn);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int n = 1; n <= 8; n++) begin
            term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        return (peak * sum + (64'sd1 <<< 29)) >>> 30;
    endfunction

    // Full-period table entry derived from the quarter wave
    function automatic int sine_entry(int idx, int depth, int width);
        int     qn;
        int     quad;
        int     k;
        longint peak;
        longint v;
        qn   = depth / 4;
        quad = idx / qn;
        k    = idx % qn;
        peak = (64'sd1 <<< (width - 1)) - 64'sd1;
        case (quad)
            0:       v =  quarter_sine(k, qn, peak);
            1:       v =  quarter_sine(qn - k, qn, peak);
            2:       v = -quarter_sine(k, qn, peak);
            default: v = -quarter_sine(qn - k, qn, peak);
        endcase
        return int'(v);
    endfunction

endpackage

// File: rtl/nco_regs.sv
// nco_regs: register port. Decodes the low address bits, holds the step,
// gain and offset registers, answers reads one cycle after the enable and
// returns the identification word for every unmapped address.
// Assumes: enables are single-cycle pulses; a write and a read in the same
// cycle are both acknowledged by one ack pulse.
module nco_regs #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int GAIN_W     = 13,
    parameter int GAIN_FRAC  = 12,
    parameter int BIAS_W     = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic                     wen_i,
    input  logic                     ren_i,
    output logic [DW-1:0]            rdata_o,
    output logic                     ack_o,
    output logic                     err_o,
    output logic [DW-1:0]            step_o,
    output logic [GAIN_W-1:0]        gain_o,
    output logic signed [BIAS_W-1:0] bias_o
);
    import nco_pkg::*;

    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

    reg_sel_e                 sel;
    logic [DW-1:0]            step_q;
    logic [GAIN_W-1:0]        gain_q;
    logic signed [BIAS_W-1:0] bias_q;
    logic [DW-1:0]            read_mux;
    logic                     unused_addr_hi;

    assign unused_addr_hi = ^addr_i[AW-1:DEC_W];

    // Decode the low address bits into a register select
    always_comb begin
        case (addr_i[DEC_W-1:0])
            OFS_STEP: sel = SEL_STEP;
            OFS_GAIN: sel = SEL_GAIN;
            OFS_BIAS: sel = SEL_BIAS;
            default:  sel = SEL_NONE;
        endcase
    end

    // Select read data: register contents or the identification word
    always_comb begin
        case (sel)
            SEL_STEP: read_mux = step_q;
            SEL_GAIN: read_mux = DW'(gain_q);
            SEL_BIAS: read_mux = {{(DW-BIAS_W){bias_q[BIAS_W-1]}}, bias_q};
            default:  read_mux = ID_WORD;
        endcase
    end

    // Capture register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            gain_q <= GAIN_UNITY;
            bias_q <= '0;
        end else if (wen_i) begin
            case (sel)
                SEL_STEP: step_q <= wdata_i;
                SEL_GAIN: gain_q <= wdata_i[GAIN_W-1:0];
                SEL_BIAS: bias_q <= wdata_i[BIAS_W-1:0];
                default:  ;
            endcase
        end
    end

    // Acknowledge each access one cycle later and register read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o <= wen_i | ren_i;
            if (ren_i) begin
                rdata_o <= read_mux;
            end
        end
    end

    assign err_o  = 1'b0;
    assign step_o = step_q;
    assign gain_o = gain_q;
    assign bias_o = bias_q;

    p_ack_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i || ren_i) |=> ack_o);

    p_no_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_i || ren_i) |=> !ack_o);

    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_i && sel == SEL_STEP) |=> $stable(step_q));

endmodule

// File: rtl/nco_phase.sv
// nco_phase: phase accumulator. Adds the step on every clock, wraps at
// 2^ACC_W and exposes the top IDX_W bits as the table index.
// Assumes: the step is already truncated to ACC_W bits by the caller.
module nco_phase #(
    parameter int ACC_W = 24,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [ACC_W-1:0] acc_q;

    // Advance the phase by the step, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + step_i;
        end
    end

    assign idx_o = acc_q[ACC_W-1 -: IDX_W];

    p_zero_step_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_sine_rom.sv
// nco_sine_rom: one full sine period, computed at elaboration, read
// through an output register (first pipeline stage).
// Assumes: DEPTH = 2^IDX_W and DEPTH is a multiple of four.
module nco_sine_rom #(
    parameter int IDX_W = 8,
    parameter int DW    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx_i,
    output logic signed [DW-1:0] sample_o
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int QUARTER = DEPTH / 4;
    localparam logic signed [DW-1:0] PEAK = DW'((1 << (DW - 1)) - 1);

    logic signed [DW-1:0] lut [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic signed [DW-1:0] ENTRY = DW'(nco_pkg::sine_entry(g, DEPTH, DW));
        assign lut[g] = ENTRY;
    end

    // Register the addressed table sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
        end else begin
            sample_o <= lut[idx_i];
        end
    end

    p_rom_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_i == '0) |=> (sample_o == '0));

    p_rom_crest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_i == IDX_W'(QUARTER)) |=> (sample_o == PEAK));

endmodule

// File: rtl/nco_scale.sv
// nco_scale: gain, offset and clipping (second pipeline stage). Widens the
// sample to the output width, multiplies by an unsigned fixed-point gain,
// floors by GAIN_FRAC bits, adds a signed offset and clips to OUT_W bits.
// Assumes: OUT_W > IN_W and BIAS_W <= OUT_W.
module nco_scale #(
    parameter int IN_W      = 10,
    parameter int OUT_W     = 14,
    parameter int GAIN_W    = 13,
    parameter int GAIN_FRAC = 12,
    parameter int BIAS_W    = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [IN_W-1:0]   sample_i,
    input  logic [GAIN_W-1:0]        gain_i,
    input  logic signed [BIAS_W-1:0] bias_i,
    output logic signed [OUT_W-1:0]  dac_o
);
    localparam int SH    = OUT_W - IN_W;
    localparam int PW    = OUT_W + GAIN_W + 1;
    localparam int MAX_I = (1 << (OUT_W - 1)) - 1;
    localparam int MIN_I = -(1 << (OUT_W - 1));

    logic signed [PW-1:0]  widened;
    logic signed [PW-1:0]  gain_s;
    logic signed [PW-1:0]  product;
    logic signed [PW-1:0]  scaled;
    logic signed [PW:0]    summed;
    logic signed [OUT_W-1:0] clipped;

    // Scale, shift and offset the sample in full width
    always_comb begin
        widened = PW'(sample_i) <<< SH;
        gain_s  = PW'($signed({1'b0, gain_i}));
        product = widened * gain_s;
        scaled  = product >>> GAIN_FRAC;
        summed  = (PW+1)'(scaled) + (PW+1)'(bias_i);
    end

    // Clip the sum to the signed output range
    always_comb begin
        if (summed > (PW+1)'(MAX_I)) begin
            clipped = OUT_W'(MAX_I);
        end else if (summed < (PW+1)'(MIN_I)) begin
            clipped = OUT_W'(MIN_I);
        end else begin
            clipped = summed[OUT_W-1:0];
        end
    end

    // Register the DAC sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_o <= '0;
        end else begin
            dac_o <= clipped;
        end
    end

    p_zero_gain_passes_bias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_i == '0) |=> (dac_o == OUT_W'($past(bias_i))));

endmodule

// File: rtl/nco_bus_sine.sv
// nco_bus_sine: top level. Register port feeds the phase accumulator, the
// table and the gain/offset stage; the index-to-output latency is two clocks.
// Assumes: single clock domain, synchronous active-low reset.
module nco_bus_sine #(
    parameter int ACC_W     = 24,
    parameter int IDX_W     = 8,
    parameter int LUT_W     = 10,
    parameter int OUT_W     = 14,
    parameter int GAIN_W    = 13,
    parameter int GAIN_FRAC = 12,
    parameter int BUS_AW    = 32,
    parameter int BUS_DW    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic [BUS_DW-1:0]       bus_wdata,
    input  logic                    bus_wen,
    input  logic                    bus_ren,
    output logic [BUS_DW-1:0]       bus_rdata,
    output logic                    bus_ack,
    output logic                    bus_err,
    output logic signed [OUT_W-1:0] dac_out,
    output logic [IDX_W-1:0]        lut_index
);
    logic [BUS_DW-1:0]       step_reg;
    logic [GAIN_W-1:0]       gain_reg;
    logic signed [OUT_W-1:0] bias_reg;
    logic signed [LUT_W-1:0] sample;
    logic                    unused_step_hi;

    assign unused_step_hi = ^step_reg[BUS_DW-1:ACC_W];

    nco_regs #(
        .AW        (BUS_AW),
        .DW        (BUS_DW),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .BIAS_W    (OUT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .wen_i   (bus_wen),
        .ren_i   (bus_ren),
        .rdata_o (bus_rdata),
        .ack_o   (bus_ack),
        .err_o   (bus_err),
        .step_o  (step_reg),
        .gain_o  (gain_reg),
        .bias_o  (bias_reg)
    );

    nco_phase #(
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_reg[ACC_W-1:0]),
        .idx_o  (lut_index)
    );

    nco_sine_rom #(
        .IDX_W (IDX_W),
        .DW    (LUT_W)
    ) u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_i    (lut_index),
        .sample_o (sample)
    );

    nco_scale #(
        .IN_W      (LUT_W),
        .OUT_W     (OUT_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .BIAS_W    (OUT_W)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .gain_i   (gain_reg),
        .bias_i   (bias_reg),
        .dac_o    (dac_out)
    );

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> !bus_err);

endmodule

// File: tb/nco_bus_sine_bench.sv
module nco_bus_sine_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic               bus_wen = 1'b0;
    logic               bus_ren = 1'b0;
    logic [31:0]        bus_rdata;
    logic               bus_ack;
    logic               bus_err;
    logic signed [13:0] dac_out;
    logic [7:0]         lut_index;

    always #10 clk = ~clk;

    nco_bus_sine u_nco_bus_sine (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wen   (bus_wen),
        .bus_ren   (bus_ren),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .dac_out   (dac_out),
        .lut_index (lut_index)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_lut [256];

    typedef struct {
        int    at;
        int    dac;
        int    idx;
        string req;
    } exp_t;

    exp_t sb [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, longint act, longint exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R2 table model from the sine definition
    function automatic int ref_sine(int i);
        real v;
        v = 511.0 * $sin(2.0 * 3.14159265358979323846 * i / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // R3 scaling and clipping model
    function automatic int ref_out(int s, int gain, int bias);
        longint p;
        p = (longint'(s) * 16 * longint'(gain)) >>> 12;
        p = p + longint'(bias);
        if (p > 8191)  p = 8191;
        if (p < -8192) p = -8192;
        return int'(p);
    endfunction

    // Monitor: pop scoreboard items as their cycle arrives
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            if (e.at != cyc) begin
                check(e.req, cyc, e.at, "scoreboard item cycle");
            end else begin
                check("R1", lut_index, e.idx, "table index");
                check(e.req, dac_out, e.dac, "dac sample");
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", dac_out, 0, "dac in reset");
        check("R9", bus_ack, 0, "ack in reset");
        check("R9", lut_index, 0, "index in reset");
        rst_n = 1'b1;
    endtask

    task automatic bus_write(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
        check("R8", bus_ack, 1, "write ack");
        check("R8", bus_err, 0, "write err");
    endtask

    task automatic bus_read(logic [31:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        bus_ren = 1'b0;
        check("R8", bus_ack, 1, "read ack");
        check(req, bus_rdata, exp, "read data");
        @(negedge clk);
        check("R8", bus_ack, 0, "ack after idle");
    endtask

    // Driver: configure, push expected items, then start the tone
    task automatic run_tone(logic [31:0] step, int gain, int bias, int n, string req);
        int     c;
        longint f24;
        do_reset();
        bus_write(32'h0001_0008, 32'(gain));
        bus_write(32'h0001_000C, 32'(bias));
        @(negedge clk);
        c   = cyc;
        f24 = longint'(step[23:0]);
        for (int j = 0; j < n; j++) begin
            exp_t   e;
            int     k;
            longint ph;
            k     = (j < 2) ? 0 : j - 2;
            ph    = (longint'(k) * f24) & 64'hFF_FFFF;
            e.dac = ref_out(ref_lut[int'(ph >> 16)], gain, bias);
            ph    = (longint'(j) * f24) & 64'hFF_FFFF;
            e.idx = int'(ph >> 16);
            e.at  = c + 1 + j;
            e.req = req;
            sb.push_back(e);
        end
        bus_addr = 32'h0001_0004; bus_wdata = step; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
        check("R8", bus_ack, 1, "step write ack");
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_lut[i] = ref_sine(i);

        do_reset();
        bus_read(32'h0001_0008, 32'h0000_1000, "R9");
        bus_read(32'h0001_000C, 32'h0000_0000, "R9");
        bus_read(32'h0001_0004, 32'h0000_0000, "R9");

        // R7 unmapped addresses
        bus_read(32'h0000_0000, 32'hFE00_2020, "R7");
        bus_read(32'h0001_0000, 32'hFE00_2020, "R7");
        bus_read(32'h0001_0010, 32'hFE00_2020, "R7");
        bus_read(32'h000F_FFFF, 32'hFE00_2020, "R7");

        // R5 upper address bits ignored, full 32-bit step readback
        bus_write(32'h4031_0004, 32'hABFF_FFFF);
        bus_read(32'h0001_0004, 32'hABFF_FFFF, "R5");
        bus_read(32'hFFF1_0004, 32'hABFF_FFFF, "R5");

        // R6 field widths and sign extension
        bus_write(32'h0001_0008, 32'hFFFF_F123);
        bus_read(32'h0001_0008, 32'h0000_1123, "R6");
        bus_write(32'h0001_000C, 32'h0000_3000);
        bus_read(32'h0001_000C, 32'hFFFF_F000, "R6");

        // R2: unity gain, step 10000, one full period
        run_tone(32'd10000, 32'h1000, 0, 1700, "R2");
        // R3: full gain with positive offset hits both clip limits
        run_tone(32'h0004_0000, 32'h1FFF, 3000, 200, "R3");
        // R4: half gain, negative offset, one index per cycle
        run_tone(32'h0001_0000, 32'h0800, -5000, 300, "R4");
        // R5: upper step bits ignored, backward wrap, zero gain
        run_tone(32'hABFF_FFFF, 0, 1234, 600, "R5");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule